// File: doc/BRIEF.md
# Dual-Clock FIFO with Conservative Occupancy Counts

This block moves data words from a writer running on one clock to a reader running on an unrelated clock. Each side gets a full/empty flag and its own registered occupancy count. The counts are biased in a fixed direction so that each side can use them for flow control. The writer's count may show more words than are stored, but never fewer. The reader's count may show fewer words than can be read, but never more.

Read and write positions are kept as binary pointers one bit wider than the RAM address. Each pointer is also held in Gray code and crosses into the other domain through two flip-flop stages. There it is turned back into binary and subtracted from the local pointer. One slot of the RAM is always left unused, so the largest occupancy is `2**ADDR_W - 1` and fits in `ADDR_W` bits. A count narrower than `ADDR_W` keeps only the top bits. This lets a 2-bit count act as a coarse quarter-level indicator.

Top module: `afifo_pess_count`

## Requirements
- R1: While its domain's reset is low at a rising edge, and after that edge, the domain shows the idle state: `full` is 0 and `wr_data_count` is 0 on the write side, `empty` is 1 and `rd_data_count` is 0 on the read side.
- R2: Words leave in the order they were accepted, with no loss or duplication. At most `2**ADDR_W - 1` words are held at once. The word for a read accepted at a `rd_clk` edge appears on `rd_data` after that same edge.
- R3: `full` is 1 when `2**ADDR_W - 1` words are held as seen from the write side. A write offered while `full` is 1 is dropped and does not change the stored contents.
- R4: A read offered while `empty` is 1 is dropped: `rd_data`, `rd_data_count` and `empty` do not change because of it.
- R5: Sampled between `wr_clk` edges, `wr_data_count` (full width) is never below the number of words stored at that moment.
- R6: Sampled between `rd_clk` edges, `rd_data_count` (full width) never exceeds the number of words that have been written and not yet read.
- R7: A local operation accepted at an edge (write: `wr_en` 1 and `full` 0; read: `rd_en` 1 and `empty` 0) is counted by the register loaded at that same edge. The write count rises by 1 at most per `wr_clk` edge. The read count falls by 1 at most per `rd_clk` edge.
- R8: An operation in the other domain reaches the local count only after a synchronizer delay. A write is not yet seen in `rd_data_count` at the first `rd_clk` falling edge after the write edge. After the other side has been idle for six local cycles, each count equals the true number of stored words.
- R9: A count of width W below `ADDR_W` equals bits `[ADDR_W-1 : ADDR_W-W]` of the full-width count.
- R10: Whenever `full` is 1, the full-width write count equals `2**ADDR_W - 1`. Whenever `empty` is 1, the full-width read count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free slot seen from the write side |
| wr_data_count | output | WCNT_W | Write-side occupancy, top bits, never low |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word read, registered |
| empty | output | 1 | Nothing readable seen from the read side |
| rd_data_count | output | RCNT_W | Read-side occupancy, top bits, never high |

## Verification
On every cycle, the assertions check three things. Dropped writes and dropped reads leave their pointers still. Each count moves at most one step per edge in the direction its own side drives it. A raised full or empty flag agrees with the count register of the same domain. The direction of the bias cannot be seen from inside either domain, because it is a relation to the true occupancy across both clocks. Only the bench's scoreboard can show it, along with the remote-update delay, the settling after idle periods, the ordering of the data and the truncated counts.

// File: rtl/afifo_pkg.sv
// Package afifo_pkg
// Holds the pointer-code conversions shared by both clock domains.
// Assumes pointer widths of 32 bits or less; callers zero-extend and truncate.
package afifo_pkg;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary, prefix XOR from the top bit down.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i + 1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync2.sv
// Module afifo_sync2
// Two-stage flip-flop synchronizer for a Gray-coded vector.
// Assumes at most one bit of the input changes between destination edges' sampling windows.
module afifo_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture and re-capture the remote vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/afifo_ram.sv
// Module afifo_ram
// Storage array with a write port on one clock and a registered read port on another.
// Assumes the controllers never address a slot that is being written and read at once.
module afifo_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int SLOTS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [SLOTS];
    logic [DATA_W-1:0] rdata_q;

    // Store an accepted word.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Fetch the word for an accepted read.
    always_ff @(posedge rclk) begin
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/afifo_wr_ctl.sv
// Module afifo_wr_ctl
// Write-domain controller: write pointer, full flag and an occupancy count that never under-reports.
// Assumes rgray_s is the read pointer in Gray code, already synchronized into this domain.
module afifo_wr_ctl
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              full,
    output logic              wr_ok,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W-1:0] wcount
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] CAP = PW'((1 << ADDR_W) - 1);

    logic [PW-1:0]     wbin_q;
    logic [PW-1:0]     wbin_nx;
    logic [PW-1:0]     wgray_q;
    logic [PW-1:0]     rbin_s;
    logic [PW-1:0]     occ_now;
    logic [ADDR_W-1:0] wcount_q;

    // Decode the remote pointer and judge whether a slot is free.
    always_comb begin
        rbin_s  = PW'(from_gray(32'(rgray_s)));
        occ_now = wbin_q - rbin_s;
        full    = (occ_now == CAP);
        wr_ok   = wr_en && !full;
        wbin_nx = wbin_q + PW'(wr_ok);
    end

    // Advance the pointer and load the count with this edge's write already included.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin_q   <= '0;
            wgray_q  <= '0;
            wcount_q <= '0;
        end else begin
            wbin_q   <= wbin_nx;
            wgray_q  <= PW'(to_gray(32'(wbin_nx)));
            wcount_q <= ADDR_W'(wbin_nx - rbin_s);
        end
    end

    assign waddr  = wbin_q[ADDR_W-1:0];
    assign wgray  = wgray_q;
    assign wcount = wcount_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wbin_q)); // R3
    AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> ({1'b0, wcount_q} == CAP)); // R10
    AST_WCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, wcount_q} <= {1'b0, $past(wcount_q)} + PW'(1)); // R7
endmodule

// File: rtl/afifo_rd_ctl.sv
// Module afifo_rd_ctl
// Read-domain controller: read pointer, empty flag and an occupancy count that never over-reports.
// Assumes wgray_s is the write pointer in Gray code, already synchronized into this domain.
module afifo_rd_ctl
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_s,
    output logic              empty,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W-1:0] rcount
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     rbin_q;
    logic [PW-1:0]     rbin_nx;
    logic [PW-1:0]     rgray_q;
    logic [PW-1:0]     wbin_s;
    logic [ADDR_W-1:0] rcount_q;

    // Decode the remote pointer and judge whether a word is readable.
    always_comb begin
        wbin_s  = PW'(from_gray(32'(wgray_s)));
        empty   = (wbin_s == rbin_q);
        rd_ok   = rd_en && !empty;
        rbin_nx = rbin_q + PW'(rd_ok);
    end

    // Advance the pointer and load the count with this edge's read already removed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin_q   <= '0;
            rgray_q  <= '0;
            rcount_q <= '0;
        end else begin
            rbin_q   <= rbin_nx;
            rgray_q  <= PW'(to_gray(32'(rbin_nx)));
            rcount_q <= ADDR_W'(wbin_s - rbin_nx);
        end
    end

    assign raddr  = rbin_q[ADDR_W-1:0];
    assign rgray  = rgray_q;
    assign rcount = rcount_q;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> $stable(rbin_q)); // R4
    AST_EMPTY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rcount_q == '0)); // R10
    AST_RCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rcount_q} + PW'(1)) >= {1'b0, $past(rcount_q)}); // R7
endmodule

// File: rtl/afifo_pess_count.sv
// Module afifo_pess_count
// Dual-clock FIFO whose write count errs high and whose read count errs low.
// Assumes both resets are applied together with their clocks running; one slot is kept free.
module afifo_pess_count #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int WCNT_W = ADDR_W,
    parameter int RCNT_W = ADDR_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic [WCNT_W-1:0] wr_data_count,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic [RCNT_W-1:0] rd_data_count
);
    localparam int PW = ADDR_W + 1;

    logic              wr_ok;
    logic              rd_ok;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_in_rd;
    logic [PW-1:0]     rgray_in_wr;
    logic [ADDR_W-1:0] wcount_full;
    logic [ADDR_W-1:0] rcount_full;

    afifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk(wr_clk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .re(rd_ok), .raddr(raddr), .rdata(rd_data)
    );

    afifo_sync2 #(.W(PW)) u_sync_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_in_wr)
    );

    afifo_sync2 #(.W(PW)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_in_rd)
    );

    afifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rgray_s(rgray_in_wr),
        .full(full), .wr_ok(wr_ok), .waddr(waddr), .wgray(wgray), .wcount(wcount_full)
    );

    afifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wgray_s(wgray_in_rd),
        .empty(empty), .rd_ok(rd_ok), .raddr(raddr), .rgray(rgray), .rcount(rcount_full)
    );

    // Keep only the most significant bits of each count.
    assign wr_data_count = wcount_full[ADDR_W-1 -: WCNT_W];
    assign rd_data_count = rcount_full[ADDR_W-1 -: RCNT_W];
endmodule

// File: tb/tb_afifo_pess_count.sv
module tb_afifo_pess_count;
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int CAP = 15;

    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       wr_rst_n = 1'b0;
    logic       rd_rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       full, empty, full_t, empty_t;
    logic [7:0] rd_data, rd_data_t;
    logic [3:0] wr_data_count, rd_data_count;
    logic [1:0] wcnt_t, rcnt_t;

    int checks = 0;
    int failures = 0;
    int wr_tot = 0;
    int rd_tot = 0;
    bit w_acc = 1'b0;
    bit r_acc = 1'b0;
    bit chk_pend = 1'b0;
    logic [7:0] exp_word;
    logic [7:0] sb [$];

    always #(WCLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    afifo_pess_count #(.DATA_W(8), .ADDR_W(4), .WCNT_W(4), .RCNT_W(4)) dut (
        .wr_clk(wclk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .wr_data_count(wr_data_count),
        .rd_clk(rclk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .rd_data_count(rd_data_count)
    );

    afifo_pess_count #(.DATA_W(8), .ADDR_W(4), .WCNT_W(2), .RCNT_W(2)) dut_trunc (
        .wr_clk(wclk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full_t), .wr_data_count(wcnt_t),
        .rd_clk(rclk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data_t),
        .empty(empty_t), .rd_data_count(rcnt_t)
    );

    // Scoreboard totals advance on the edge that accepts the operation.
    always @(posedge wclk) if (w_acc) wr_tot++;
    always @(posedge rclk) if (r_acc) rd_tot++;

    function automatic int stored();
        return wr_tot - rd_tot;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One write-clock step: check the write side, then drive the next request.
    task automatic wr_step(input bit en, input logic [7:0] d);
        @(negedge wclk);
        chk(int'(wr_data_count) >= stored(), "R5 wr count below stored", int'(wr_data_count), stored());
        chk(wcnt_t == wr_data_count[3:2], "R9 truncated wr count", int'(wcnt_t), int'(wr_data_count[3:2]));
        wr_en   = en;
        wr_data = d;
        w_acc   = en && !full;
        if (w_acc) sb.push_back(d);
    endtask

    // One read-clock step: check data and the read side, then drive the next request.
    task automatic rd_step(input bit en);
        @(negedge rclk);
        if (chk_pend) chk(rd_data == exp_word, "R2 data order", int'(rd_data), int'(exp_word));
        chk(int'(rd_data_count) <= stored(), "R6 rd count above readable", int'(rd_data_count), stored());
        chk(rcnt_t == rd_data_count[3:2], "R9 truncated rd count", int'(rcnt_t), int'(rd_data_count[3:2]));
        rd_en = en;
        r_acc = en && !empty;
        if (r_acc) exp_word = sb.pop_front();
        chk_pend = r_acc;
    endtask

    initial begin
        #(2000000);
        failures++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] hold;
        void'($urandom(32'd4242));
        repeat (5) @(negedge wclk);
        repeat (5) @(negedge rclk);
        @(negedge wclk) wr_rst_n = 1'b1;
        @(negedge rclk) rd_rst_n = 1'b1;

        // R1: idle state after reset
        @(negedge wclk);
        chk(full == 1'b0, "R1 full after reset", int'(full), 0);
        chk(wr_data_count == 4'd0, "R1 wr count after reset", int'(wr_data_count), 0);
        @(negedge rclk);
        chk(empty == 1'b1, "R1 empty after reset", int'(empty), 1);
        chk(rd_data_count == 4'd0, "R1 rd count after reset", int'(rd_data_count), 0);

        // R7 / R8: single write, local vs remote visibility
        wr_step(1'b1, 8'hA5);
        @(posedge wclk);
        #1;
        wr_en = 1'b0;
        w_acc = 1'b0;
        @(negedge rclk);
        chk(rd_data_count == 4'd0, "R8 remote write seen too early", int'(rd_data_count), 0);
        @(negedge wclk);
        chk(wr_data_count == 4'd1, "R7 own write in wr count", int'(wr_data_count), 1);
        repeat (6) rd_step(1'b0);
        chk(rd_data_count == 4'd1, "R8 rd count settled", int'(rd_data_count), 1);
        rd_step(1'b1);
        rd_step(1'b0);
        chk(rd_data_count == 4'd0, "R7 own read in rd count", int'(rd_data_count), 0);
        repeat (6) wr_step(1'b0, 8'h00);
        chk(wr_data_count == 4'd0, "R8 wr count settled", int'(wr_data_count), 0);

        // R4: read while empty is dropped
        hold = rd_data;
        rd_step(1'b1);
        rd_step(1'b0);
        chk(rd_data == hold, "R4 rd_data after empty read", int'(rd_data), int'(hold));
        chk(rd_data_count == 4'd0, "R4 rd count after empty read", int'(rd_data_count), 0);
        chk(empty == 1'b1, "R4 empty after empty read", int'(empty), 1);

        // R3 / R10: overfill, extra writes dropped
        for (int i = 0; i < 20; i++) wr_step(1'b1, 8'(8'h40 + i));
        wr_step(1'b0, 8'h00);
        chk(full == 1'b1, "R3 full at capacity", int'(full), 1);
        chk(wr_data_count == 4'(CAP), "R10 wr count at full", int'(wr_data_count), CAP);
        chk(stored() == CAP, "R2 capacity", stored(), CAP);
        chk(wcnt_t == 2'd3, "R9 truncated wr count at full", int'(wcnt_t), 3);
        for (int i = 0; i < 40; i++) rd_step(sb.size() > 0);
        rd_step(1'b0);
        chk(sb.size() == 0, "R3 dropped writes not stored", sb.size(), 0);

        // Random traffic from both sides at once
        fork
            begin
                for (int i = 0; i < 1500; i++) wr_step($urandom_range(99) < 55, 8'($urandom));
                wr_step(1'b0, 8'h00);
            end
            begin
                for (int i = 0; i < 1100; i++) rd_step($urandom_range(99) < 50);
                rd_step(1'b0);
            end
        join

        // R8: both idle, counts settle to the stored number
        repeat (8) rd_step(1'b0);
        chk(int'(rd_data_count) == stored(), "R8 rd count after idle", int'(rd_data_count), stored());
        repeat (2) wr_step(1'b0, 8'h00);
        chk(int'(wr_data_count) == stored(), "R8 wr count after idle", int'(wr_data_count), stored());

        for (int i = 0; i < 60 && sb.size() > 0; i++) rd_step(1'b1);
        rd_step(1'b0);
        chk(sb.size() == 0, "R2 all words read", sb.size(), 0);
        repeat (8) rd_step(1'b0);
        chk(empty == 1'b1, "R10 empty after drain", int'(empty), 1);
        chk(rd_data_count == 4'd0, "R10 rd count after drain", int'(rd_data_count), 0);
        finish_run();
    end
endmodule